// File: doc/BRIEF.md
# Periodic Clock Stretching Gate

This block slows a processor clock on average by dropping single pulses at a fixed spacing. A counter runs on the source clock. When the counter reaches the interval that software has written, the gate holds the output clock low for exactly one source period. The counter then restarts and the clock runs normally until the next match. The removal pattern therefore repeats every N source clocks, where N is the programmed interval.

Software programs the block through a plain write port: a write strobe, write data and a read-back bus. There is no separate enable bit. The first write of a non-zero interval starts the stretching. Writing zero turns the feature off again. After power-up the clock passes through unchanged until a write arrives.

The gate is a low-transparent latch followed by an AND gate, so the output never carries a shortened pulse. A per-cycle enable output shows the gate decision so that the removal pattern can be observed. There is no data stream here, so there is no valid/ready handshake: every pin is plain control.

Top module: `clk_stretch_gate`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets. Afterwards `cfg_rdata` is 0, `clk_en` is 1 and `clk_out` follows `clk_src`.
- R2: Until a non-zero interval has been written, `clk_en` stays 1 and no source pulse is removed.
- R3: A write of N ≥ 2 while stretching is off starts the pattern as follows. With the write sampled at rising edge e, `clk_en` is 0 only during the cycle before edge e+N, and the same happens again every N edges after that.
- R4: `clk_out` has a high phase after a rising edge of `clk_src` exactly when `clk_en` was 1 just before that edge, and it is low for the whole removed period.
- R5: A written value of 1 is stored and applied as 2.
- R6: A write of 0 while stretching is active lets the current count finish and remove its pulse. After that, `clk_en` stays 1.
- R7: A value written while stretching is active takes effect at the next wrap, which is the cycle in which `clk_en` is 0. A write sampled on that same wrap edge is the value loaded.
- R8: `cfg_rdata` shows the last written value, after clamping, from the cycle after the write.
- R9: `clk_en` is never 0 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the interval register |
| cfg_wdata | input | W | Interval to program (0 turns off, 1 is taken as 2) |
| cfg_rdata | output | W | Programmed interval, after clamping |
| clk_out | output | 1 | Gated output clock |
| clk_en | output | 1 | Gate decision that applies to the next rising edge |

## Verification
The read-back value is due one edge after the write strobe is sampled. The bench therefore checks it at the falling edge that follows the write. A gate decision made in cycle k shows on `clk_out` during the high phase after edge k+1. The reference model computes, at each rising edge, the decision that applies to that edge and queues it. The monitor then checks `clk_out` 1 ns after the edge and checks `clk_en` at the next falling edge, so neither check samples a signal while it is changing.

// File: rtl/clkstr_pkg.sv
package clkstr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } str_state_e;
endpackage

// File: rtl/clkstr_cfg.sv
module clkstr_cfg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] wval_o,
  output logic [W-1:0] pend_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] pend_q;

  // a value of 1 would hold the clock off forever, so it becomes 2
  always_comb begin
    wval_o = (wdata_i == ONE) ? TWO : wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    pend_q <= '0;
    else if (we_i)  pend_q <= wval_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/clkstr_seq.sv
module clkstr_seq
  import clkstr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wval_i,
  input  logic [W-1:0] pend_i,
  output logic         en_o,
  output logic         armed_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] active_o
);
  localparam logic [W-1:0] ONE = W'(1);

  str_state_e   st_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic         wrap;
  logic [W-1:0] next_val;

  assign wrap     = (st_q == ST_RUN) && (cnt_q == act_q - ONE);
  // a write on the wrap edge wins over the stored value
  assign next_val = we_i ? wval_i : pend_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      act_q <= '0;
    end else if (st_q == ST_IDLE) begin
      cnt_q <= '0;
      if (we_i) begin
        act_q <= wval_i;
        st_q  <= (wval_i != '0) ? ST_RUN : ST_IDLE;
      end
    end else if (wrap) begin
      cnt_q <= '0;
      act_q <= next_val;
      st_q  <= (next_val != '0) ? ST_RUN : ST_IDLE;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign en_o     = !wrap;
  assign armed_o  = (st_q == ST_RUN);
  assign cnt_o    = cnt_q;
  assign active_o = act_q;
endmodule

// File: rtl/clkstr_icg.sv
module clkstr_icg (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent while the clock is low, so the enable is frozen for the high phase
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/clk_stretch_gate.sv
module clk_stretch_gate #(
  parameter int W = 8
) (
  input  logic         clk_src,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic         clk_out,
  output logic         clk_en
);
  logic [W-1:0] wval;
  logic [W-1:0] pend;
  logic         en;
  logic         armed;
  logic [W-1:0] cnt;
  logic [W-1:0] active;

  clkstr_cfg #(.W(W)) u_cfg (
    .clk_i   (clk_src),
    .rst_ni  (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .wval_o  (wval),
    .pend_o  (pend)
  );

  clkstr_seq #(.W(W)) u_seq (
    .clk_i    (clk_src),
    .rst_ni   (rst_n),
    .we_i     (cfg_we),
    .wval_i   (wval),
    .pend_i   (pend),
    .en_o     (en),
    .armed_o  (armed),
    .cnt_o    (cnt),
    .active_o (active)
  );

  clkstr_icg u_icg (
    .clk_i  (clk_src),
    .en_i   (en),
    .gclk_o (clk_out)
  );

  assign cfg_rdata = pend;
  assign clk_en    = en;
endmodule

// File: rtl/clk_stretch_gate_chk.sv
module clk_stretch_gate_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clk_en_i,
  input logic         armed_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] active_i,
  input logic [W-1:0] rdata_i
);
  AST_RESET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> clk_en_i);                                    // R1
  AST_IDLE_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> clk_en_i);                                         // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> (cnt_i < active_i));                                // R3
  AST_NO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i != W'(1));                                              // R5
  AST_HOLD_TO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && clk_en_i) |=> $stable(active_i));                   // R7
  AST_SINGLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> clk_en_i);                                        // R9
endmodule

bind clk_stretch_gate clk_stretch_gate_chk #(.W(W)) u_chk (
  .clk_i    (clk_src),
  .rst_ni   (rst_n),
  .clk_en_i (clk_en),
  .armed_i  (armed),
  .cnt_i    (cnt),
  .active_i (active),
  .rdata_i  (cfg_rdata)
);

// File: tb/clk_stretch_gate_tb.sv
module clk_stretch_gate_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cfg_rdata;
  logic         clk_out;
  logic         clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_pend = 0, m_act = 0, m_cnt = 0;
  bit m_arm = 1'b0;
  bit exp_q[$];
  bit m_en_now;

  always #2 clk = ~clk;

  clk_stretch_gate #(.W(W)) u_dut (
    .clk_src (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata), .clk_out (clk_out), .clk_en (clk_en)
  );

  function automatic int clampv(int v);
    return (v == 1) ? 2 : v;
  endfunction

  function automatic bit model_en();
    return !(m_arm && (m_cnt == m_act - 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // scoreboard producer: decision for this edge, then advance the model
  always @(posedge clk) begin
    int wv, nv;
    m_en_now = model_en();
    exp_q.push_back(m_en_now);
    wv = clampv(int'(cfg_wdata));
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_cnt = 0; m_arm = 0;
    end else begin
      if (!m_arm) begin
        m_cnt = 0;
        if (cfg_we) begin m_act = wv; m_arm = (wv != 0); end
      end else if (m_cnt == m_act - 1) begin
        nv = cfg_we ? wv : m_pend;
        m_act = nv; m_arm = (nv != 0); m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (cfg_we) m_pend = wv;
    end
  end

  // scoreboard consumer
  always @(posedge clk) begin
    bit e;
    #1;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      if (rst_n)
        check(clk_out == e, "R4 R3 gated clock high phase", int'(clk_out), int'(e));
    end
  end

  always @(negedge clk) begin
    if (rst_n)
      check(clk_en == model_en(), "R3 R6 R7 R9 enable pattern", int'(clk_en), int'(model_en()));
  end

  task automatic wr(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    check(int'(cfg_rdata) == clampv(v), "R8 R5 read-back", int'(cfg_rdata), clampv(v));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == '0, "R1 reset read-back", int'(cfg_rdata), 0);
    check(clk_en == 1'b1, "R1 reset enable", int'(clk_en), 1);
    idle(10);                       // R2 ungated before any write
    wr(3); idle(20);                // R3 period 3
    wr(5); idle(30);                // R7 change at wrap
    wr(1);                          // R5 clamp to 2
    idle(20);
    wr(0); idle(15);                // R6 turn off after wrap
    check(clk_en == 1'b1, "R6 off stays ungated", int'(clk_en), 1);
    wr(4); idle(3);                 // R3 restart, write near wrap
    wr(2); idle(20);
    wr(7); idle(10);
    rst_n = 1'b0; idle(2);
    rst_n = 1'b1; @(negedge clk);
    check(cfg_rdata == '0, "R1 reset mid-run", int'(cfg_rdata), 0);
    check(clk_en == 1'b1, "R1 enable after reset", int'(clk_en), 1);
    idle(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule